// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable, cycle-accurate model of a pipelined synchronous static RAM. Reads and writes can be issued on consecutive clocks in any mix, with no idle cycle between them. Control, address and byte-lane enables are all captured on the rising clock edge. Read data is registered once more before it reaches the outputs. Write data arrives two edges after its command. A read that targets a word whose write is still in flight returns the merged value.

A cycle is started only when the load strobe is low. While the strobe is high, the block continues the previous operation at an address it generates itself. That address steps through a four-beat burst in either linear or interleaved order. One active-low chip enable gates the data path. Two bank enables, each with a static polarity input, gate both the data path and the echo-clock enable. This lets several devices share a bus in depth expansion.

Top module: `pipe_sram`

## Requirements
- R1: A synchronous reset leaves the outputs with rvalid=0, rdata all zero and echo_en=0. Holding load_n high after reset keeps that state, whatever the other inputs do.
- R2: A read is started on an edge where load_n=0, chip_en_n=0, both bank enables are active and read_nwrite=1. The word at addr appears on rdata with rvalid=1 after the next rising edge.
- R3: A write is started like a read but with read_nwrite=0. Lane i is bits [9i+8:9i] and is written only when lane_we_n[i]=0, sampled on the command (or beat) edge. The data is taken from wdata on the second rising edge after that edge. Lanes with lane_we_n[i]=1 keep their stored value.
- R4: bank_pol_a=1 makes bank_en_a active high, and bank_pol_a=0 makes it active low. bank_pol_b sets bank_en_b the same way. chip_en_n is always active low.
- R5: With burst_ilv=0, load_n=1 after a read or write continues that operation. The low two address bits become (base+k) mod 4 at beat k, and the upper bits stay fixed. A fifth beat returns to the loaded address.
- R6: With burst_ilv=1, the low two address bits at beat k are base XOR k.
- R7: load_n=1 after a deselect cycle keeps the device deselected.
- R8: After the edge that follows a deselect or write cycle, rvalid=0 and rdata is all zero.
- R9: echo_en follows the bank enables with the same latency as rvalid. A deselect made only by chip_en_n=1 keeps echo_en=1. A bank enable sampled inactive clears echo_en.
- R10: Reads and writes can alternate on consecutive edges, and every read returns the last data written to its address.
- R11: A read issued on the edge right after a write to the same address returns the write's enabled lanes over the old contents of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en_n | input | 1 | Data-path chip enable, active low |
| bank_en_a | input | 1 | First bank enable, sense set by bank_pol_a |
| bank_en_b | input | 1 | Second bank enable, sense set by bank_pol_b |
| bank_pol_a | input | 1 | Static: 1 = bank_en_a active high |
| bank_pol_b | input | 1 | Static: 1 = bank_en_b active high |
| load_n | input | 1 | 0 = start a new cycle, 1 = continue the burst |
| read_nwrite | input | 1 | 1 = read, 0 = write |
| lane_we_n | input | LANES (8) | Active-low write enable per 9-bit lane |
| burst_ilv | input | 1 | Static: 1 = interleaved, 0 = linear burst |
| addr | input | AW (8) | Word address |
| wdata | input | DW (72) | Write data, taken two edges after the command |
| rdata | output | DW (72) | Registered read data, zero when not valid |
| rvalid | output | 1 | Read data valid |
| echo_en | output | 1 | Echo-clock enable |

## Verification
A command stage that holds the wrong operation shows up exactly two edges after the command, as a wrong rvalid or echo_en. A burst counter or base register that has gone astray puts another word's data on rdata at the very next beat. Wrap and interleave errors therefore surface within four reads. A missing or misaligned forward shows only on the single read that directly follows a write to the same word. That read comes back with stale lanes, which is why stored words are built from distinct per-lane patterns.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

   // Operation held in the command stage
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

endpackage

// File: rtl/pipe_sram_sel_decode.sv
module pipe_sram_sel_decode (
   input  logic chip_en_n,
   input  logic bank_en_a,
   input  logic bank_en_b,
   input  logic bank_pol_a,
   input  logic bank_pol_b,
   output logic bank_ok,
   output logic sel
);

   // A bank enable is active when its level equals its polarity input
   assign bank_ok = (bank_en_a == bank_pol_a) && (bank_en_b == bank_pol_b);
   assign sel     = bank_ok && !chip_en_n;

endmodule

// File: rtl/pipe_sram_burst.sv
module pipe_sram_burst #(
   parameter int AW = 8,
   parameter int BB = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic          step,
   input  logic          ilv,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_q
);

   logic [AW-1:0] base_q;
   logic [BB-1:0] cnt_q;
   logic [BB-1:0] cnt_nx;
   logic [BB-1:0] lo_nx;
   logic [AW-1:0] step_addr;

   always_comb begin
      cnt_nx = cnt_q + 1'b1;
      if (ilv) lo_nx = base_q[BB-1:0] ^ cnt_nx;
      else     lo_nx = base_q[BB-1:0] + cnt_nx;
   end

   generate
      if (AW > BB) begin : g_upper
         assign step_addr = {base_q[AW-1:BB], lo_nx};

         AST_BURST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
            (step && !load) |=> $stable(addr_q[AW-1:BB])); // R5
      end else begin : g_flat
         assign step_addr = lo_nx;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         cnt_q  <= '0;
         addr_q <= '0;
      end else if (load) begin
         base_q <= addr_in;
         cnt_q  <= '0;
         addr_q <= addr_in;
      end else if (step) begin
         cnt_q  <= cnt_nx;
         addr_q <= step_addr;
      end
   end

   AST_BURST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
      load |=> (cnt_q == '0 && addr_q == $past(addr_in))); // R5

endmodule

// File: rtl/pipe_sram_lane_bank.sv
module pipe_sram_lane_bank #(
   parameter int AW = 8,
   parameter int W  = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   localparam int WORDS = 2 ** AW;

   logic [W-1:0] store [WORDS];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/pipe_sram_fwd_merge.sv
module pipe_sram_fwd_merge #(
   parameter int LANES = 8,
   parameter int LW    = 9,
   localparam int DW   = LANES * LW
) (
   input  logic [DW-1:0]    stored,
   input  logic [DW-1:0]    pend,
   input  logic [LANES-1:0] pend_be_n,
   input  logic             hit,
   output logic [DW-1:0]    merged
);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign merged[i*LW +: LW] = (hit && !pend_be_n[i]) ? pend[i*LW +: LW]
                                                            : stored[i*LW +: LW];
      end
   endgenerate

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
   import pipe_sram_pkg::*;
#(
   parameter int DEPTH      = 256,
   parameter int LANES      = 8,
   parameter int LANE_W     = 9,
   parameter int BURST_BITS = 2,
   localparam int AW        = $clog2(DEPTH),
   localparam int DW        = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             chip_en_n,
   input  logic             bank_en_a,
   input  logic             bank_en_b,
   input  logic             bank_pol_a,
   input  logic             bank_pol_b,
   input  logic             load_n,
   input  logic             read_nwrite,
   input  logic [LANES-1:0] lane_we_n,
   input  logic             burst_ilv,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic             rvalid,
   output logic             echo_en
);

   // Elaboration checks
   generate
      if (DEPTH != (2 ** AW) || DEPTH < (2 ** BURST_BITS)) begin : g_bad_depth
         $error("pipe_sram: DEPTH must be a power of two holding one burst");
      end
      if (BURST_BITS < 1 || LANES < 1 || LANE_W < 1) begin : g_bad_shape
         $error("pipe_sram: BURST_BITS, LANES and LANE_W must be positive");
      end
   endgenerate

   logic             bank_ok;
   logic             sel;

   // Command stage
   op_e              s1_op;
   logic             s1_echo;
   logic [LANES-1:0] s1_be_n;
   logic [AW-1:0]    s1_addr;
   logic             beat_step;

   // Late-write stage
   logic             s2_wr;
   logic [AW-1:0]    s2_addr;
   logic [LANES-1:0] s2_be_n;

   logic [DW-1:0]    stored_word;
   logic [DW-1:0]    read_word;
   logic             fwd_hit;

   pipe_sram_sel_decode u_decode (
      .chip_en_n  (chip_en_n),
      .bank_en_a  (bank_en_a),
      .bank_en_b  (bank_en_b),
      .bank_pol_a (bank_pol_a),
      .bank_pol_b (bank_pol_b),
      .bank_ok    (bank_ok),
      .sel        (sel)
   );

   assign beat_step = load_n && (s1_op != OP_IDLE);

   pipe_sram_burst #(.AW(AW), .BB(BURST_BITS)) u_burst (
      .clk     (clk),
      .rst     (rst),
      .load    (!load_n),
      .step    (beat_step),
      .ilv     (burst_ilv),
      .addr_in (addr),
      .addr_q  (s1_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_op   <= OP_IDLE;
         s1_echo <= 1'b0;
         s1_be_n <= '1;
      end else begin
         s1_be_n <= lane_we_n;
         if (!load_n) begin
            if (!sel)             s1_op <= OP_IDLE;
            else if (read_nwrite) s1_op <= OP_READ;
            else                  s1_op <= OP_WRITE;
            s1_echo <= bank_ok;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_wr   <= 1'b0;
         s2_addr <= '0;
         s2_be_n <= '1;
      end else begin
         s2_wr   <= (s1_op == OP_WRITE);
         s2_addr <= s1_addr;
         s2_be_n <= s1_be_n;
      end
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_bank
         pipe_sram_lane_bank #(.AW(AW), .W(LANE_W)) u_bank (
            .clk   (clk),
            .we    (s2_wr && !s2_be_n[i]),
            .waddr (s2_addr),
            .wdata (wdata[i*LANE_W +: LANE_W]),
            .raddr (s1_addr),
            .rdata (stored_word[i*LANE_W +: LANE_W])
         );
      end
   endgenerate

   assign fwd_hit = s2_wr && (s2_addr == s1_addr);

   pipe_sram_fwd_merge #(.LANES(LANES), .LW(LANE_W)) u_merge (
      .stored    (stored_word),
      .pend      (wdata),
      .pend_be_n (s2_be_n),
      .hit       (fwd_hit),
      .merged    (read_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rvalid  <= 1'b0;
         rdata   <= '0;
         echo_en <= 1'b0;
      end else begin
         rvalid  <= (s1_op == OP_READ);
         rdata   <= (s1_op == OP_READ) ? read_word : '0;
         echo_en <= s1_echo;
      end
   end

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (!load_n && sel && read_nwrite) |-> ##2 (rvalid && echo_en)); // R2
   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!load_n && !sel) |-> ##2 (!rvalid && rdata == '0)); // R8
   AST_DESEL_STAYS: assert property (@(posedge clk) disable iff (rst)
      (load_n && s1_op == OP_IDLE) |-> ##2 !rvalid); // R7
   AST_ECHO_DROP: assert property (@(posedge clk) disable iff (rst)
      (!load_n && !bank_ok) |-> ##2 !echo_en); // R9
   AST_ECHO_KEEP: assert property (@(posedge clk) disable iff (rst)
      (!load_n && bank_ok && chip_en_n) |-> ##2 echo_en); // R9

endmodule

// File: tb/pipe_sram_test.sv
`timescale 1ns/1ps
module pipe_sram_test;

   localparam int LANES = 8;
   localparam int LW    = 9;
   localparam int DW    = 72;
   localparam int AW    = 8;

   logic             clk = 1'b0;
   logic             rst;
   logic             chip_en_n, bank_en_a, bank_en_b, bank_pol_a, bank_pol_b;
   logic             load_n, read_nwrite, burst_ilv;
   logic [LANES-1:0] lane_we_n;
   logic [AW-1:0]    addr;
   logic [DW-1:0]    wdata;
   logic [DW-1:0]    rdata;
   logic             rvalid, echo_en;

   int errors = 0;
   int checks = 0;

   pipe_sram uut (
      .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .bank_en_a(bank_en_a),
      .bank_en_b(bank_en_b), .bank_pol_a(bank_pol_a), .bank_pol_b(bank_pol_b),
      .load_n(load_n), .read_nwrite(read_nwrite), .lane_we_n(lane_we_n),
      .burst_ilv(burst_ilv), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rvalid(rvalid), .echo_en(echo_en)
   );

   always #4 clk = ~clk;

   // Expected lane merge from R3: lane i takes new data when be_n[i] is 0
   function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [LANES-1:0] be_n);
      logic [DW-1:0] r;
      for (int i = 0; i < LANES; i++)
         r[i*LW +: LW] = be_n[i] ? old_w[i*LW +: LW] : new_w[i*LW +: LW];
      return r;
   endfunction

   localparam logic [DW-1:0] NO = 72'd0;
   localparam logic [DW-1:0] DA = {8{9'h0A5}};
   localparam logic [DW-1:0] DB = {8{9'h14B}};
   localparam logic [DW-1:0] DC = {8{9'h1F0}};
   localparam logic [DW-1:0] DM = merge_lanes(DA, DC, 8'hF0);
   localparam logic [DW-1:0] W0 = {8{9'h031}};
   localparam logic [DW-1:0] W1 = {8{9'h0C2}};
   localparam logic [DW-1:0] W2 = {8{9'h153}};
   localparam logic [DW-1:0] W3 = {8{9'h1E4}};

   typedef struct packed {
      logic             ld, c1, ca, cb, rw;
      logic [LANES-1:0] be;
      logic [AW-1:0]    a;
      logic [DW-1:0]    wd;
      logic             ev;
      logic [DW-1:0]    ed;
      logic             ee;
      int               req;
   } vec_t;

   // Polarity during the table: bank_en_a active high, bank_en_b active low.
   // Expected outputs reflect the command of the previous row.
   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h10,NO,1'b0,NO,1'b0,8},  // R8 idle before
      '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h20,NO,1'b0,NO,1'b1,8},  // R8 write gives no data
      '{1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h10,DA,1'b0,NO,1'b1,10}, // R10 read after write
      '{1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h20,DB,1'b1,DA,1'b1,10}, // R10 R2
      '{1'b0,1'b0,1'b1,1'b0,1'b0,8'hF0,8'h10,NO,1'b1,DB,1'b1,10}, // R10 write after read
      '{1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h10,NO,1'b0,NO,1'b1,10}, // R10 read after write
      '{1'b0,1'b1,1'b1,1'b0,1'b1,8'h00,8'h00,DC,1'b1,DM,1'b1,11}, // R11 forwarded merge
      '{1'b1,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,NO,1'b0,NO,1'b1,9},  // R9 chip_en_n keeps echo
      '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,8'h00,NO,1'b0,NO,1'b1,7},  // R7 continuation stays idle
      '{1'b1,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,NO,1'b0,NO,1'b0,9},  // R9 bank off drops echo
      '{1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'h10,NO,1'b0,NO,1'b0,7},  // R7
      '{1'b0,1'b1,1'b1,1'b0,1'b1,8'h00,8'h00,NO,1'b1,DM,1'b1,3},  // R3 masked lanes kept
      '{1'b0,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,NO,1'b0,NO,1'b1,9},  // R9
      '{1'b1,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,NO,1'b0,NO,1'b0,4}   // R4 active-low bank_en_b
   };

   task automatic drive(input logic ld, input logic c1, input logic ca, input logic cb,
                        input logic rw, input logic [LANES-1:0] be,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd);
      load_n = ld; chip_en_n = c1; bank_en_a = ca; bank_en_b = cb;
      read_nwrite = rw; lane_we_n = be; addr = a; wdata = wd;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic ev, input logic [DW-1:0] ed,
                        input logic ee);
      checks++;
      if (rvalid !== ev || rdata !== ed || echo_en !== ee) begin
         errors++;
         $display("FAIL %s: got rvalid=%0b rdata=%h echo_en=%0b, expected rvalid=%0b rdata=%h echo_en=%0b",
                  tag, rvalid, rdata, echo_en, ev, ed, ee);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      rst = 1'b1; bank_pol_a = 1'b1; bank_pol_b = 1'b0; burst_ilv = 1'b0;
      load_n = 1'b1; chip_en_n = 1'b1; bank_en_a = 1'b0; bank_en_b = 1'b1;
      read_nwrite = 1'b1; lane_we_n = '1; addr = '0; wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R1", 1'b0, NO, 1'b0);
      // R1: continuation strobe after reset never starts a cycle
      for (int k = 0; k < 3; k++) begin
         drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h10, NO);
         check("R1", 1'b0, NO, 1'b0);
      end

      for (int k = 0; k < NV; k++) begin
         drive(TBL[k].ld, TBL[k].c1, TBL[k].ca, TBL[k].cb, TBL[k].rw,
               TBL[k].be, TBL[k].a, TBL[k].wd);
         check($sformatf("R%0d", TBL[k].req), TBL[k].ev, TBL[k].ed, TBL[k].ee);
      end

      // R5 write burst from 0x42: beats hit 0x42,0x43,0x40,0x41
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h42, NO);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, NO);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, W0);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, W1);
      drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, W2);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, W3);

      // R5 linear read burst from 0x41, fifth beat wraps to the base
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h41, NO);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R5", 1'b1, W3, 1'b1);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R5", 1'b1, W0, 1'b1);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R5", 1'b1, W1, 1'b1);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R5", 1'b1, W2, 1'b1);
      drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R5", 1'b1, W3, 1'b1);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R8", 1'b0, NO, 1'b1);

      // R6 interleaved read burst from 0x41: 0x41,0x40,0x43,0x42
      burst_ilv = 1'b1;
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h41, NO);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R6", 1'b1, W3, 1'b1);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R6", 1'b1, W2, 1'b1);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R6", 1'b1, W1, 1'b1);
      drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R6", 1'b1, W0, 1'b1);
      burst_ilv = 1'b0;

      // R4 reversed polarity: bank_en_a active low, bank_en_b active high
      bank_pol_a = 1'b0; bank_pol_b = 1'b1;
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h10, NO);
      drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h10, NO);
      check("R4", 1'b1, DM, 1'b1);
      drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, NO);
      check("R4", 1'b0, NO, 1'b0);
      bank_pol_a = 1'b1; bank_pol_b = 1'b0;

      // R1 reset in the middle of a read
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h10, NO);
      rst = 1'b1;
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      rst = 1'b0;
      check("R1", 1'b0, NO, 1'b0);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, NO);
      check("R1", 1'b0, NO, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule